// File: doc/BRIEF.md
# Packed Saturating Vector Subtractor

This unit subtracts one packed integer vector from another lane by lane. Every lane result is clamped to the range its element type can hold, so it never wraps. The element width is chosen per operation from a 2-bit code: 8, 16, 32 or 64 bits. One borrow chain serves all four widths and is cut at the lane edges. Each lane is treated as signed two's complement or as unsigned, according to a select input.

An operation covers either one 64-bit half or both halves of a 128-bit vector. The wide form carries three register indices. If any of these indices is odd, the unit marks the beat as undefined, returns a zero result and leaves its flag untouched. A sticky flag records that some lane was clamped. Subtractions only ever set this flag, and a separate clear input is the only way to reset it.

Operands enter on a valid/ready handshake and results leave on one, through a single output register. The input is ready whenever that register is empty or is being drained in the same cycle. While the consumer holds ready low, a pending result keeps its value.

Top module: `psub_sat_unit`

## Requirements
- R1: Code `esz` sets the lane width to 8<<esz bits (0=8, 1=16, 2=32, 3=64). Lane e of a half sits at bits [e*w +: w] with lane 0 lowest, and no borrow crosses a lane edge.
- R2: With `uns`=1, each lane returns a-b when a>=b and 0 otherwise; it never wraps.
- R3: With `uns`=0, each lane returns the exact signed difference, clamped to [-2^(w-1), 2^(w-1)-1].
- R4: With `quad`=0, only bits [63:0] are computed. Bits [127:64] of the result are zero, and upper-half operands cannot set the sticky flag.
- R5: With `quad`=1, both 64-bit halves are processed with the same width and signedness.
- R6: When `quad`=1 and bit 0 of `dst_idx`, `srca_idx` or `srcb_idx` is 1, the beat returns `out_undef`=1 and a zero result, and the sticky flag keeps its value.
- R7: An accepted legal operation in which any active lane clamps sets `sat_sticky` on the next cycle. No operation ever clears it.
- R8: `clr_sat`=1 makes `sat_sticky` 0 on the next cycle, and wins over a set in the same cycle.
- R9: `in_ready` = !`out_valid` || `out_ready`. An accepted beat appears on the outputs one cycle later. While `out_valid`=1 and `out_ready`=0, the result and undefined flag stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Unit can take a beat |
| opa | input | 128 | Minuend vector |
| opb | input | 128 | Subtrahend vector |
| esz | input | 2 | Lane width code |
| uns | input | 1 | 1 = unsigned lanes, 0 = signed |
| quad | input | 1 | 1 = 128-bit form, 0 = 64-bit form |
| dst_idx | input | 5 | Destination register index (legality only) |
| srca_idx | input | 5 | First source index (legality only) |
| srcb_idx | input | 5 | Second source index (legality only) |
| clr_sat | input | 1 | Clear the sticky flag |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_res | output | 128 | Packed clamped result |
| out_undef | output | 1 | Beat was an illegal wide form |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
Every width and signedness pair is driven with pseudo-random vectors in the wide form, and each result is compared against an arithmetic model of the exact difference. Hand-picked extremes each probe one failure mode:
- most-negative minus one, and most-positive minus minus-one, separate the two signed clamp directions;
- an unsigned byte borrow placed next to a non-borrowing neighbour shows whether the borrow leaks across the lane edge;
- saturating upper halves in the narrow form check that the upper half is both zeroed and kept away from the flag.

Odd indices check the undefined path. A clear issued alongside a saturating beat tells a clear that takes priority from one that does not, and a stalled consumer shows whether the result is held.

// File: rtl/psub_pkg.sv
package psub_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ESZ_B8  = 2'd0,
    ESZ_B16 = 2'd1,
    ESZ_B32 = 2'd2,
    ESZ_B64 = 2'd3
  } esz_e;

  // bytes per lane for a width code
  function automatic int unsigned lane_bytes(input esz_e code);
    return 32'd1 << int'(code);
  endfunction
endpackage

// File: rtl/psub_borrow_chain.sv
// Byte-sliced subtract whose borrow chain is cut at every lane edge.
module psub_borrow_chain
  import psub_pkg::*;
#(
  parameter int unsigned HALF_W = 64
) (
  input  logic [HALF_W-1:0]                a_i,
  input  logic [HALF_W-1:0]                b_i,
  input  esz_e                             esz_i,
  output logic [HALF_W-1:0]                diff_o,
  output logic [HALF_W/BYTE_W-1:0]         bout_o
);
  localparam int unsigned NB = HALF_W / BYTE_W;

  always_comb begin
    logic             brw;
    logic [BYTE_W:0]  t;
    int unsigned      lb;
    lb     = lane_bytes(esz_i);
    brw    = 1'b0;
    diff_o = '0;
    bout_o = '0;
    for (int k = 0; k < NB; k++) begin
      if ((k % lb) == 0) brw = 1'b0;
      t = {1'b0, a_i[k*BYTE_W +: BYTE_W]} - {1'b0, b_i[k*BYTE_W +: BYTE_W]}
          - {{BYTE_W{1'b0}}, brw};
      diff_o[k*BYTE_W +: BYTE_W] = t[BYTE_W-1:0];
      bout_o[k]                  = t[BYTE_W];
      brw                        = t[BYTE_W];
    end
  end
endmodule

// File: rtl/psub_clamp.sv
// Per-lane overflow detection and clamp; every byte looks at its lane's top byte.
module psub_clamp
  import psub_pkg::*;
#(
  parameter int unsigned HALF_W = 64
) (
  input  logic [HALF_W-1:0]        a_i,
  input  logic [HALF_W-1:0]        b_i,
  input  logic [HALF_W-1:0]        diff_i,
  input  logic [HALF_W/BYTE_W-1:0] bout_i,
  input  esz_e                     esz_i,
  input  logic                     uns_i,
  output logic [HALF_W-1:0]        res_o,
  output logic                     sat_o
);
  localparam int unsigned NB = HALF_W / BYTE_W;

  always_comb begin
    int unsigned lb;
    int unsigned top;
    logic        sa, sb, sd, ovf;
    lb    = lane_bytes(esz_i);
    res_o = '0;
    sat_o = 1'b0;
    for (int k = 0; k < NB; k++) begin
      top = k | (lb - 1);
      sa  = a_i[top*BYTE_W + BYTE_W - 1];
      sb  = b_i[top*BYTE_W + BYTE_W - 1];
      sd  = diff_i[top*BYTE_W + BYTE_W - 1];
      ovf = uns_i ? bout_i[top] : ((sa != sb) && (sd != sa));
      if (!ovf)
        res_o[k*BYTE_W +: BYTE_W] = diff_i[k*BYTE_W +: BYTE_W];
      else if (uns_i)
        res_o[k*BYTE_W +: BYTE_W] = '0;
      else if (k == top)
        res_o[k*BYTE_W +: BYTE_W] = sa ? {1'b1, {(BYTE_W-1){1'b0}}}
                                       : {1'b0, {(BYTE_W-1){1'b1}}};
      else
        res_o[k*BYTE_W +: BYTE_W] = sa ? {BYTE_W{1'b0}} : {BYTE_W{1'b1}};
      if (ovf && (k == top)) sat_o = 1'b1;
    end
  end
endmodule

// File: rtl/psub_sat_unit.sv
module psub_sat_unit
  import psub_pkg::*;
#(
  parameter int unsigned HALF_W = 64,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*HALF_W-1:0]   opa,
  input  logic [2*HALF_W-1:0]   opb,
  input  logic [1:0]            esz,
  input  logic                  uns,
  input  logic                  quad,
  input  logic [IDX_W-1:0]      dst_idx,
  input  logic [IDX_W-1:0]      srca_idx,
  input  logic [IDX_W-1:0]      srcb_idx,
  input  logic                  clr_sat,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [2*HALF_W-1:0]   out_res,
  output logic                  out_undef,
  output logic                  sat_sticky
);
  localparam int unsigned NHALF = 2;
  localparam int unsigned VEC_W = NHALF * HALF_W;
  localparam int unsigned NB    = HALF_W / BYTE_W;

  esz_e               esz_t;
  logic [VEC_W-1:0]   res_next;
  logic [NHALF-1:0]   half_sat;
  logic [NHALF-1:0]   half_on;
  logic               illegal;
  logic               accept;

  assign esz_t = esz_e'(esz);

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [HALF_W-1:0] diff, res;
    logic [NB-1:0]     bout;
    logic              sat;

    psub_borrow_chain #(.HALF_W(HALF_W)) u_chain (
      .a_i    (opa[h*HALF_W +: HALF_W]),
      .b_i    (opb[h*HALF_W +: HALF_W]),
      .esz_i  (esz_t),
      .diff_o (diff),
      .bout_o (bout)
    );

    psub_clamp #(.HALF_W(HALF_W)) u_clamp (
      .a_i    (opa[h*HALF_W +: HALF_W]),
      .b_i    (opb[h*HALF_W +: HALF_W]),
      .diff_i (diff),
      .bout_i (bout),
      .esz_i  (esz_t),
      .uns_i  (uns),
      .res_o  (res),
      .sat_o  (sat)
    );

    if (h == 0) begin : g_base
      assign half_on[h] = 1'b1;
    end else begin : g_ext
      assign half_on[h] = quad;
    end

    assign res_next[h*HALF_W +: HALF_W] = half_on[h] ? res : '0;
    assign half_sat[h]                  = half_on[h] & sat;
  end

  assign illegal  = quad & (dst_idx[0] | srca_idx[0] | srcb_idx[0]);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_undef <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_res   <= illegal ? '0 : res_next;
      out_undef <= illegal;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sat_sticky <= 1'b0;
    else if (clr_sat)
      sat_sticky <= 1'b0;
    else if (accept && !illegal && (|half_sat))
      sat_sticky <= 1'b1;
  end
endmodule

// File: rtl/psub_sat_unit_chk.sv
module psub_sat_unit_chk #(
  parameter int unsigned HALF_W = 64,
  parameter int unsigned IDX_W  = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                quad,
  input logic [IDX_W-1:0]    dst_idx,
  input logic [IDX_W-1:0]    srca_idx,
  input logic [IDX_W-1:0]    srcb_idx,
  input logic                clr_sat,
  input logic                out_valid,
  input logic                out_ready,
  input logic [2*HALF_W-1:0] out_res,
  input logic                out_undef,
  input logic                sat_sticky
);
  logic take, odd_wide;
  assign take     = in_valid && in_ready;
  assign odd_wide = quad && (dst_idx[0] || srca_idx[0] || srcb_idx[0]);

  assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take && !quad |=> out_res[2*HALF_W-1:HALF_W] == '0);

  assert_undef_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take && odd_wide |=> out_undef && (out_res == '0));

  assert_undef_keeps_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take && odd_wide && !clr_sat |=> sat_sticky == $past(sat_sticky));

  assert_flag_falls_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sat_sticky) |-> $past(clr_sat));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sat |=> !sat_sticky);

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_undef));

  assert_accept_delivers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
endmodule

bind psub_sat_unit psub_sat_unit_chk #(.HALF_W(HALF_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .quad(quad), .dst_idx(dst_idx), .srca_idx(srca_idx), .srcb_idx(srcb_idx),
  .clr_sat(clr_sat), .out_valid(out_valid), .out_ready(out_ready),
  .out_res(out_res), .out_undef(out_undef), .sat_sticky(sat_sticky)
);

// File: tb/tb_psub_sat_unit.sv
`timescale 1ns/1ps
module tb_psub_sat_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready;
  logic [127:0] opa, opb;
  logic [1:0]   esz;
  logic         uns, quad;
  logic [4:0]   dst_idx, srca_idx, srcb_idx;
  logic         clr_sat;
  logic         out_valid, out_ready;
  logic [127:0] out_res;
  logic         out_undef, sat_sticky;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  exp_sticky = 1'b0;

  always #4 clk = ~clk;

  psub_sat_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opa(opa), .opb(opb), .esz(esz), .uns(uns), .quad(quad),
    .dst_idx(dst_idx), .srca_idx(srca_idx), .srcb_idx(srcb_idx),
    .clr_sat(clr_sat), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_undef(out_undef), .sat_sticky(sat_sticky)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // arithmetic model of one operation
  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input int code, input bit u, input bit q,
                                         output bit sat);
    int w, nl, sh;
    logic [63:0] m, la, lb, lr;
    logic signed [67:0] ea, eb, d, mx, mn, one;
    logic [127:0] r;
    r = '0; sat = 1'b0; one = 68'sd1;
    w = 8 << code; nl = 64 / w;
    m = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    for (int h = 0; h < (q ? 2 : 1); h++) begin
      for (int e = 0; e < nl; e++) begin
        sh = h*64 + e*w;
        la = 64'(a >> sh) & m;
        lb = 64'(b >> sh) & m;
        ea = $signed({4'b0, la});
        eb = $signed({4'b0, lb});
        if (!u) begin
          if (la[w-1]) ea = ea - (one <<< w);
          if (lb[w-1]) eb = eb - (one <<< w);
        end
        d  = ea - eb;
        mx = u ? ((one <<< w) - one) : ((one <<< (w-1)) - one);
        mn = u ? 68'sd0 : -(one <<< (w-1));
        if (d > mx) begin d = mx; sat = 1'b1; end
        if (d < mn) begin d = mn; sat = 1'b1; end
        lr = d[63:0] & m;
        r  = r | ({64'd0, lr} << sh);
      end
    end
    return r;
  endfunction

  // one accepted beat, result checked on the following negedge
  task automatic run_op(input string req, input logic [127:0] a, input logic [127:0] b,
                        input int code, input bit u, input bit q,
                        input logic [4:0] rd, input logic [4:0] rn, input logic [4:0] rm,
                        input bit clr);
    logic [127:0] exp;
    bit sat, bad;
    exp = model(a, b, code, u, q, sat);
    bad = q && (rd[0] || rn[0] || rm[0]);
    if (bad) exp = '0;
    @(negedge clk);
    opa = a; opb = b; esz = 2'(code); uns = u; quad = q;
    dst_idx = rd; srca_idx = rn; srcb_idx = rm; clr_sat = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; clr_sat = 1'b0;
    if (clr) exp_sticky = 1'b0;
    else if (!bad && sat) exp_sticky = 1'b1;
    chk({req, " valid"}, {127'd0, out_valid}, 128'd1);
    chk({req, " result"}, out_res, exp);
    chk({req, " undef"}, {127'd0, out_undef}, {127'd0, bad});
    chk({req, " sticky"}, {127'd0, sat_sticky}, {127'd0, exp_sticky});
  endtask

  task automatic t_reset;
    chk("R9 reset out_valid", {127'd0, out_valid}, 128'd0);
    chk("R7 reset sticky", {127'd0, sat_sticky}, 128'd0);
    chk("R9 reset in_ready", {127'd0, in_ready}, 128'd1);
  endtask

  task automatic t_lane_edges;
    // R1: u8, byte0 0-1 clamps to 0 while byte1 (1-0) keeps 1: no borrow leak
    run_op("R1 u8 lane edge", 128'h0100, 128'h0001, 0, 1, 0, 0, 0, 0, 0);
    chk("R1 u8 lane edge value", out_res, 128'h0100);
    // same operands as u16: one lane, 0x0100-1 = 0x00FF
    run_op("R1 u16 one lane", 128'h0100, 128'h0001, 1, 1, 0, 0, 0, 0, 1);
    chk("R1 u16 value", out_res, 128'h00FF);
  endtask

  task automatic t_extremes;
    run_op("R3 s8 min-1", 128'h80, 128'h01, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 s8 min clamp", out_res, 128'h80);
    run_op("R3 s8 max-(-1)", 128'h7F, 128'hFF, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 s8 max clamp", out_res, 128'h7F);
    run_op("R3 s64 min-1", 128'h8000_0000_0000_0000, 128'h1, 3, 0, 0, 0, 0, 0, 0);
    run_op("R2 u64 0-1", 128'h0, 128'h1, 3, 1, 0, 0, 0, 0, 0);
    chk("R2 u64 floor", out_res, 128'h0);
    run_op("R2 u32 no sat", 128'h0000_0009_0000_0005, 128'h0000_0002_0000_0005,
           2, 1, 0, 0, 0, 0, 1);
    chk("R2 u32 exact", out_res, 128'h0000_0007_0000_0000);
  endtask

  task automatic t_random;
    for (int code = 0; code < 4; code++) begin
      for (int u = 0; u < 2; u++) begin
        for (int i = 0; i < 6; i++) begin
          logic [127:0] a, b;
          a = {$urandom, $urandom, $urandom, $urandom};
          b = {$urandom, $urandom, $urandom, $urandom};
          if (i == 0) b = a;
          run_op("R5 wide random", a, b, code, bit'(u), 1, 2, 4, 6, bit'(i == 3));
        end
      end
    end
  endtask

  task automatic t_narrow;
    // upper halves would saturate; lower is clean
    run_op("R4 narrow upper", {64'h0, 64'h5}, {64'hFFFF_FFFF_FFFF_FFFF, 64'h3},
           0, 1, 0, 1, 3, 5, 1);
    chk("R4 upper zero", {64'd0, out_res[127:64]}, 128'd0);
    chk("R4 sticky untouched", {127'd0, sat_sticky}, 128'd0);
  endtask

  task automatic t_undef;
    run_op("R6 odd srca", 128'h0, 128'h1, 0, 1, 1, 0, 1, 0, 1);
    run_op("R6 odd dst", 128'h0, 128'h1, 0, 1, 1, 3, 0, 0, 0);
    chk("R6 flag kept clear", {127'd0, sat_sticky}, 128'd0);
    run_op("R7 set", 128'h0, 128'h1, 0, 1, 0, 0, 0, 0, 0);
    run_op("R6 odd srcb set flag", 128'h5, 128'h5, 0, 1, 1, 0, 0, 7, 0);
    chk("R6 flag kept set", {127'd0, sat_sticky}, 128'd1);
    run_op("R7 clean op keeps flag", 128'h5, 128'h3, 0, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_clear;
    run_op("R8 clear beats set", 128'h0, 128'h1, 0, 1, 0, 0, 0, 0, 1);
    chk("R8 cleared", {127'd0, sat_sticky}, 128'd0);
  endtask

  task automatic t_stall;
    logic [127:0] held;
    @(negedge clk);
    out_ready = 1'b0;
    opa = 128'h10; opb = 128'h3; esz = 2'd0; uns = 1'b1; quad = 1'b0;
    dst_idx = '0; srca_idx = '0; srcb_idx = '0; in_valid = 1'b1;
    @(negedge clk);
    held = out_res;
    chk("R9 one cycle latency", held, 128'h0D);
    chk("R9 ready low on stall", {127'd0, in_ready}, 128'd0);
    opa = 128'hFF; opb = 128'h0;     // offered while stalled
    @(negedge clk);
    chk("R9 held under stall", out_res, held);
    chk("R9 still valid", {127'd0, out_valid}, 128'd1);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 drained", {127'd0, out_valid}, 128'd0);
    chk("R9 ignored beat", out_res, held);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; clr_sat = 1'b0;
    opa = '0; opb = '0; esz = '0; uns = 1'b0; quad = 1'b0;
    dst_idx = '0; srca_idx = '0; srcb_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lane_edges();
    t_extremes();
    t_narrow();
    t_undef();
    t_clear();
    t_random();
    t_stall();
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end
endmodule